// File: doc/BRIEF.md
# Logarithmic Multiply, Divide and Square-Root Unit

This block is the short-vector multiplicative datapath for a processor whose real numbers are kept in logarithmic form. Each 32-bit word has a sign flag in bit 31. Bits 30:0 hold the base-2 logarithm of the magnitude as a 31-bit two's complement fixed-point number with 8 integer bits and 23 fraction bits. In this form, multiplying two numbers adds their logarithms and dividing subtracts them. A square root halves the logarithm with a one-place arithmetic right shift. Each operation therefore costs one fixed-point adder or one wire shift.

Four identical lanes run side by side, so one accepted request yields four results together. In broadcast mode, the second operand of lane 0 is applied to every lane. This lets one scalar scale or divide a whole vector. Two reserved words stand for zero and NaN, and every lane folds special operands, range overflow and range underflow onto those two codes. A request is taken on any clock with the valid strobe high. Its results are registered and appear one clock later.

Top module: `lns_muldiv_root`

## Requirements
- R1: Opcode 00 multiplies. If neither operand is zero or NaN, the result logarithm is the two's complement sum of the operand logarithms, and the result sign is the XOR of the operand signs. Zero is the word 0x40000000 and NaN is the word 0xC0000000.
- R2: Opcode 01 divides lane operand a by lane operand b. If neither operand is zero or NaN, the result logarithm is a's logarithm minus b's, and the result sign is the XOR of the operand signs.
- R3: Opcode 10 takes the square root of operand a and ignores operand b. A positive operand gives a positive sign with the logarithm arithmetically shifted right by one place. The zero word gives the zero word. A negative non-zero operand gives NaN.
- R4: A sum or difference that is greater than 0x3FFFFFFF, read as a signed 31-bit value, returns NaN.
- R5: A sum or difference that is at or below -2^30 (the reserved most-negative logarithm) returns the zero word.
- R6: A NaN in any operand that the opcode reads returns NaN. This covers a and b for multiply and divide, and a alone for square root.
- R7: For multiply, a zero operand returns zero. For divide, a zero divisor returns NaN (including zero over zero), and a zero dividend over a non-zero, non-NaN divisor returns zero.
- R8: Opcode 11 is reserved and returns NaN in every lane, unless R6 already gives NaN.
- R9: With the broadcast input high, every lane uses lane 0's b operand as its b operand. With it low, each lane uses its own b operand.
- R10: Results and out_valid update one clock after a request with in_valid high. out_valid then equals the in_valid of the previous clock. While in_valid is low the results hold their value. Reset clears results and out_valid to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| op_sel | input | 2 | 00 multiply, 01 divide, 10 square root, 11 reserved |
| bcast | input | 1 | Apply lane 0's b operand to all lanes |
| a_vec | input | 128 | Operand a, lane k in bits 32k+31:32k |
| b_vec | input | 128 | Operand b, lane k in bits 32k+31:32k |
| res_vec | output | 128 | Registered results, same lane layout |
| out_valid | output | 1 | Result strobe |

## Verification
The main sweep crosses a set of 22 words for every opcode. The set covers both signs of logarithms placed just above the reserved minimum, around zero, at odd small values and at the top of the range, plus the zero and NaN words. Pairs of extreme logarithms separate a correct overflow or underflow fold from a wrapped adder. Pairs near zero and odd values check sign XOR and the rounding direction of the square-root shift. Because each lane of a request gets a different a operand, a swap between lanes shows up. Separate broadcast requests give every lane its own b operand, so a lane that ignores the broadcast is exposed. Idle clocks with changing inputs check that the results hold.

// File: rtl/lns_pkg.sv
package lns_pkg;
  localparam int WORD_W = 32;
  localparam int LOG_W  = WORD_W - 1;

  typedef logic [WORD_W-1:0] lns_word_t;
  typedef logic signed [LOG_W:0] log_ext_t;   // one guard bit above the logarithm

  typedef enum logic [1:0] {
    OP_MUL  = 2'b00,
    OP_DIV  = 2'b01,
    OP_SQRT = 2'b10,
    OP_RSVD = 2'b11
  } lns_op_e;

  localparam lns_word_t ZERO_WORD = {1'b0, 1'b1, {(LOG_W-1){1'b0}}};
  localparam lns_word_t NAN_WORD  = {1'b1, 1'b1, {(LOG_W-1){1'b0}}};

  localparam log_ext_t LOG_MAX = {2'b00, {(LOG_W-1){1'b1}}};
  localparam log_ext_t LOG_MIN = {2'b11, {(LOG_W-1){1'b0}}};

  function automatic logic is_zero(input lns_word_t w);
    return w == ZERO_WORD;
  endfunction

  function automatic logic is_nan(input lns_word_t w);
    return w == NAN_WORD;
  endfunction

  function automatic log_ext_t widen(input lns_word_t w);
    return {w[LOG_W-1], w[LOG_W-1:0]};
  endfunction

  function automatic logic too_big(input log_ext_t s);
    return s > LOG_MAX;
  endfunction

  function automatic logic too_small(input log_ext_t s);
    return s <= LOG_MIN;
  endfunction
endpackage

// File: rtl/lns_operand_route.sv
module lns_operand_route
  import lns_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [LANES*WORD_W-1:0] b_in,
  input  logic                    bcast,
  output logic [LANES*WORD_W-1:0] b_out
);
  generate
    for (genvar k = 0; k < LANES; k++) begin : g_route
      if (k == 0) begin : g_first
        assign b_out[WORD_W-1:0] = b_in[WORD_W-1:0];
      end else begin : g_rest
        assign b_out[k*WORD_W +: WORD_W] =
          bcast ? b_in[WORD_W-1:0] : b_in[k*WORD_W +: WORD_W];
      end
    end
  endgenerate
endmodule

// File: rtl/lns_lane.sv
module lns_lane
  import lns_pkg::*;
(
  input  lns_op_e   op,
  input  lns_word_t a,
  input  lns_word_t b,
  output lns_word_t y,
  output logic      ovf,
  output logic      unf,
  output logic      nan_in
);
  logic     a_z, b_z, a_n, b_n, sgn;
  log_ext_t sum, dif, pick, half;
  logic     use_range;

  assign a_z  = is_zero(a);
  assign b_z  = is_zero(b);
  assign a_n  = is_nan(a);
  assign b_n  = is_nan(b);
  assign sum  = widen(a) + widen(b);
  assign dif  = widen(a) - widen(b);
  assign half = widen(a) >>> 1;
  assign sgn  = a[WORD_W-1] ^ b[WORD_W-1];
  assign pick = (op == OP_DIV) ? dif : sum;

  assign nan_in = a_n || (b_n && op != OP_SQRT);

  // The range path applies only to multiply/divide with ordinary operands.
  assign use_range = !nan_in && (op == OP_MUL || op == OP_DIV) && !a_z && !b_z;
  assign ovf = use_range && too_big(pick);
  assign unf = use_range && too_small(pick);

  always_comb begin
    y = NAN_WORD;
    if (nan_in) begin
      y = NAN_WORD;
    end else begin
      unique case (op)
        OP_MUL: begin
          if (a_z || b_z)  y = ZERO_WORD;
          else if (ovf)    y = NAN_WORD;
          else if (unf)    y = ZERO_WORD;
          else             y = {sgn, pick[LOG_W-1:0]};
        end
        OP_DIV: begin
          if (b_z)         y = NAN_WORD;
          else if (a_z)    y = ZERO_WORD;
          else if (ovf)    y = NAN_WORD;
          else if (unf)    y = ZERO_WORD;
          else             y = {sgn, pick[LOG_W-1:0]};
        end
        OP_SQRT: begin
          if (a_z)                 y = ZERO_WORD;
          else if (a[WORD_W-1])    y = NAN_WORD;
          else                     y = {1'b0, half[LOG_W-1:0]};
        end
        default: y = NAN_WORD;
      endcase
    end
  end
endmodule

// File: rtl/lns_muldiv_root.sv
module lns_muldiv_root
  import lns_pkg::*;
#(
  parameter int LANES = 4,
  localparam int VEC_W = LANES * WORD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       op_sel,
  input  logic             bcast,
  input  logic [VEC_W-1:0] a_vec,
  input  logic [VEC_W-1:0] b_vec,
  output logic [VEC_W-1:0] res_vec,
  output logic             out_valid
);
  logic [VEC_W-1:0] b_eff;
  logic [VEC_W-1:0] lane_y;
  logic [LANES-1:0] lane_ovf, lane_unf, lane_nan;
  lns_op_e          op;

  assign op = lns_op_e'(op_sel);

  lns_operand_route #(.LANES(LANES)) u_route (
    .b_in (b_vec),
    .bcast(bcast),
    .b_out(b_eff)
  );

  generate
    for (genvar k = 0; k < LANES; k++) begin : g_lane
      lns_lane u_lane (
        .op    (op),
        .a     (a_vec[k*WORD_W +: WORD_W]),
        .b     (b_eff[k*WORD_W +: WORD_W]),
        .y     (lane_y[k*WORD_W +: WORD_W]),
        .ovf   (lane_ovf[k]),
        .unf   (lane_unf[k]),
        .nan_in(lane_nan[k])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_vec   <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) res_vec <= lane_y;
    end
  end
endmodule

// File: rtl/lns_muldiv_root_chk.sv
module lns_muldiv_root_chk
  import lns_pkg::*;
#(
  parameter int LANES = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic [1:0]              op_sel,
  input logic                    out_valid,
  input logic [LANES*WORD_W-1:0] res_vec,
  input logic [LANES-1:0]        lane_ovf,
  input logic [LANES-1:0]        lane_unf,
  input logic [LANES-1:0]        lane_nan
);
  p_valid_up_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_down_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(res_vec));

  generate
    for (genvar k = 0; k < LANES; k++) begin : g_chk
      p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lane_ovf[k]) |=> res_vec[k*WORD_W +: WORD_W] == NAN_WORD);
      p_underflow_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lane_unf[k]) |=> res_vec[k*WORD_W +: WORD_W] == ZERO_WORD);
      p_nan_prop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lane_nan[k]) |=> res_vec[k*WORD_W +: WORD_W] == NAN_WORD);
      p_one_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lane_ovf[k], lane_unf[k], lane_nan[k]}));
      p_root_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 2'b10) |=>
          (res_vec[k*WORD_W + WORD_W-1] == 1'b0 ||
           res_vec[k*WORD_W +: WORD_W] == NAN_WORD));
    end
  endgenerate
endmodule

bind lns_muldiv_root lns_muldiv_root_chk #(.LANES(LANES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .op_sel   (op_sel),
  .out_valid(out_valid),
  .res_vec  (res_vec),
  .lane_ovf (lane_ovf),
  .lane_unf (lane_unf),
  .lane_nan (lane_nan)
);

// File: tb/lns_muldiv_root_test.sv
`timescale 1ns/1ps
module lns_muldiv_root_test;
  localparam int L = 4;
  localparam int NW = 22;
  localparam logic [31:0] ZW = 32'h4000_0000;
  localparam logic [31:0] NN = 32'hC000_0000;
  localparam longint LMAX = 64'sd1073741823;
  localparam longint LMIN = -64'sd1073741824;

  logic clk = 0, rst_n = 0, in_valid = 0, bcast = 0;
  logic [1:0] op_sel = 0;
  logic [L*32-1:0] a_vec = '0, b_vec = '0;
  logic [L*32-1:0] res_vec;
  logic out_valid;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  lns_muldiv_root uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .bcast(bcast), .a_vec(a_vec), .b_vec(b_vec), .res_vec(res_vec), .out_valid(out_valid));

  function automatic logic [31:0] pick_word(int idx);
    longint logs [10] = '{-1073741823, -1073741822, -536870912, -1, 0, 1, 3,
                          536870912, 1073741822, 1073741823};
    longint v;
    if (idx == 20) return ZW;
    if (idx == 21) return NN;
    v = logs[idx/2];
    return {idx[0], v[30:0]};
  endfunction

  function automatic longint lg(logic [31:0] w);
    return longint'($signed(w[30:0]));
  endfunction

  function automatic logic [31:0] model(int op, logic [31:0] a, logic [31:0] b,
                                        output string tag);
    longint s;
    if (a == NN || (op != 2 && b == NN)) begin tag = "R6"; return NN; end
    if (op == 3) begin tag = "R8"; return NN; end
    if (op == 2) begin
      tag = "R3";
      if (a == ZW) return ZW;
      if (a[31]) return NN;
      s = lg(a) >>> 1;
      return {1'b0, s[30:0]};
    end
    if (op == 0) begin
      if (a == ZW || b == ZW) begin tag = "R7"; return ZW; end
      s = lg(a) + lg(b); tag = "R1";
    end else begin
      if (b == ZW) begin tag = "R7"; return NN; end
      if (a == ZW) begin tag = "R7"; return ZW; end
      s = lg(a) - lg(b); tag = "R2";
    end
    if (s > LMAX) begin tag = "R4"; return NN; end
    if (s <= LMIN) begin tag = "R5"; return ZW; end
    return {a[31] ^ b[31], s[30:0]};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp, int lane);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s lane %0d: actual=%h expected=%h", tag, lane, act, exp);
    end
  endtask

  // Drive one request at the falling edge, check one clock later.
  task automatic issue_and_check(int op, bit bc);
    logic [31:0] exp [L];
    string tg [L];
    @(negedge clk);
    op_sel = 2'(op); bcast = bc; in_valid = 1;
    for (int k = 0; k < L; k++)
      exp[k] = model(op, a_vec[k*32 +: 32], bc ? b_vec[31:0] : b_vec[k*32 +: 32], tg[k]);
    @(posedge clk); #1;
    for (int k = 0; k < L; k++)
      check(bc ? {tg[k], "/R9"} : tg[k], res_vec[k*32 +: 32], exp[k], k);
    total++;
    if (out_valid !== 1'b1) begin
      bad++; $display("FAIL R10 out_valid actual=%b expected=1", out_valid);
    end
  endtask

  initial begin
    logic [L*32-1:0] held;
    repeat (3) @(posedge clk);
    #1;
    check("R10", res_vec[31:0], 32'h0, 0);
    total++;
    if (out_valid !== 1'b0) begin
      bad++; $display("FAIL R10 reset out_valid actual=%b expected=0", out_valid);
    end
    @(negedge clk); rst_n = 1;

    // Sweep: every opcode, every a (rotated across lanes), every b.
    for (int op = 0; op < 4; op++)
      for (int i = 0; i < NW; i++)
        for (int j = 0; j < NW; j++) begin
          for (int k = 0; k < L; k++) begin
            a_vec[k*32 +: 32] = pick_word((i + k) % NW);
            b_vec[k*32 +: 32] = pick_word((j + 3*k) % NW);
          end
          issue_and_check(op, 0);
        end

    // Broadcast: lanes carry distinct b words, lane 0's must be used by all.
    for (int op = 0; op < 2; op++)
      for (int j = 0; j < NW; j++) begin
        for (int k = 0; k < L; k++) begin
          a_vec[k*32 +: 32] = pick_word((2*k + 5) % 20);
          b_vec[k*32 +: 32] = pick_word((j + 7*k + 1) % NW);
        end
        issue_and_check(op, 1);
      end

    // Idle clocks: inputs change, results must hold and out_valid drop (R10).
    held = res_vec;
    for (int n = 0; n < 4; n++) begin
      @(negedge clk);
      in_valid = 0; a_vec = {L{32'h0000_0001}}; b_vec = {L{32'h8000_0002}};
      op_sel = 2'(n);
      @(posedge clk); #1;
      total++;
      if (res_vec !== held) begin
        bad++; $display("FAIL R10 hold actual=%h expected=%h", res_vec, held);
      end
      total++;
      if (out_valid !== 1'b0) begin
        bad++; $display("FAIL R10 idle out_valid actual=%b expected=0", out_valid);
      end
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule